// File: doc/BRIEF.md
# Single-Wire Bus ROM Command Layer

This block is the network-addressing stage of a slave on a single-wire bus. Each time the bit-slot front end reports a bus reset, the block collects an 8-bit ROM command from the master's write slots. That command decides whether this device takes part in the memory command that follows. The device carries a fixed 64-bit identity: an 8-bit family code in bits 7:0, a 48-bit serial number in bits 55:8, and an 8-bit check byte in bits 63:56. The check byte is computed from the first 56 bits.

The block does not produce any slot timing itself. The front end gives it three things:
- a one-cycle strobe for every master write slot, with the bit that was received;
- a one-cycle strobe for every master read slot, which consumes the `tx_bit` presented just before;
- a reset strobe, with a qualifier that says whether the reset was long enough to return the bus to standard speed.

The block drives a `selected` flag for the memory layer and an `overdrive` flag for the slot timer. `tx_bit` is 1 whenever the device is not driving a value; that level is the released state of an open-drain line.

Top module: `owr_rom_layer`

## Requirements
- R1: After `rst`, `selected` is 0, `overdrive` is 0, `tx_bit` is 1, and the resume flag is clear, so Resume (A5h) does not select the device.
- R2: After a bus reset, the next 8 write slots form the command, least significant bit first. A code other than 33h, 55h, F0h, CCh, A5h, 3Ch or 69h leaves the device unselected with `tx_bit` at 1, and every slot is ignored until the next bus reset.
- R3: Read ROM (33h) presents identity bits 0 to 63 on `tx_bit`, one per read slot. Bits 63:56 equal the CRC-8 of bits 55:0, with polynomial x^8+x^5+x^4+1, initial value 0, and bits taken least significant first. `selected` rises after the 64th read slot.
- R4: Match ROM (55h) takes 64 write slots. `selected` rises only if every bit equals the identity. On the first unequal bit the device goes idle until the next reset.
- R5: Search ROM (F0h) handles identity bit i, from 0 to 63, as a triplet. The first read slot gives bit i, the second read slot gives its complement, and then a write slot gives the master's choice. A choice unequal to bit i releases `tx_bit` and drops the device until reset. After bit 63 `selected` rises.
- R6: A successful Match, Search or Overdrive Match sets the resume flag. A failed Match, Search or Overdrive Match clears it, and so do Skip and Overdrive Skip.
- R7: Resume (A5h) sets `selected` right after the command if the resume flag is set. Otherwise the device goes idle.
- R8: Skip ROM (CCh) sets `selected` right after the command and leaves `overdrive` unchanged. While `selected` is 1, `tx_bit` is 1.
- R9: Overdrive Skip (3Ch) sets `selected` and `overdrive` right after the command.
- R10: Overdrive Match (69h) sets `overdrive` right after the command byte and then acts as Match. If the match fails, `overdrive` goes back to the value it had before the command.
- R11: `overdrive` is cleared only by a bus reset with `reset_long` high. A bus reset with `reset_long` low keeps it.
- R12: Every bus reset clears `selected` and restarts command collection. Slots that arrive before the first bus reset after `rst` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_reset | input | 1 | One-cycle strobe: reset pulse seen on the wire |
| reset_long | input | 1 | Qualifies `bus_reset`: the pulse was long enough to restore standard speed |
| wr_slot | input | 1 | One-cycle strobe: a master write slot has completed |
| wr_bit | input | 1 | Bit received in that write slot |
| rd_slot | input | 1 | One-cycle strobe: a master read slot has consumed `tx_bit` |
| tx_bit | output | 1 | Bit offered for the next read slot (1 = line released) |
| selected | output | 1 | Device is addressed for the memory command |
| overdrive | output | 1 | Overdrive speed is in effect |

## Verification
Every strobe is taken at a rising edge, and the state it causes shows on the outputs one register later. `selected`, `overdrive` and the next `tx_bit` are therefore due in the cycle after the strobe that completes a command byte, a match bit, a search triplet or a read slot. The bench drives each strobe for one cycle starting at a falling edge. It compares outputs at the next falling edge, or later, and it reads `tx_bit` before it pulses the read slot that consumes it. Sweeps place a mismatched bit at each of the 64 identity positions in both Match and Search. After each, the bench issues a reset and a Resume to expose the resume flag at the ports.

// File: rtl/owr_pkg.sv
package owr_pkg;
    localparam int ID_W  = 64;
    localparam int IDX_W = $clog2(ID_W);

    localparam logic [7:0] CMD_READ     = 8'h33;
    localparam logic [7:0] CMD_MATCH    = 8'h55;
    localparam logic [7:0] CMD_SEARCH   = 8'hF0;
    localparam logic [7:0] CMD_SKIP     = 8'hCC;
    localparam logic [7:0] CMD_RESUME   = 8'hA5;
    localparam logic [7:0] CMD_OD_SKIP  = 8'h3C;
    localparam logic [7:0] CMD_OD_MATCH = 8'h69;

    typedef enum logic [2:0] {
        ST_WAIT, ST_CMD, ST_READ, ST_MATCH, ST_S_TRUE, ST_S_COMP, ST_S_PICK, ST_SEL
    } owr_state_e;

    typedef enum logic [2:0] {
        OP_READ, OP_MATCH, OP_SEARCH, OP_SKIP, OP_RESUME, OP_OD_SKIP, OP_OD_MATCH, OP_NONE
    } owr_op_e;

    function automatic owr_op_e decode_cmd(input logic [7:0] code);
        case (code)
            CMD_READ:     return OP_READ;
            CMD_MATCH:    return OP_MATCH;
            CMD_SEARCH:   return OP_SEARCH;
            CMD_SKIP:     return OP_SKIP;
            CMD_RESUME:   return OP_RESUME;
            CMD_OD_SKIP:  return OP_OD_SKIP;
            CMD_OD_MATCH: return OP_OD_MATCH;
            default:      return OP_NONE;
        endcase
    endfunction

    // Reflected CRC-8, polynomial x^8+x^5+x^4+1, bits fed LSB first.
    function automatic logic [7:0] crc8_of(input logic [55:0] data);
        logic [7:0] c;
        logic       mix;
        c = 8'h00;
        for (int i = 0; i < 56; i++) begin
            mix = c[0] ^ data[i];
            c   = {mix, c[7:1]};
            c[3] = c[3] ^ mix;
            c[2] = c[2] ^ mix;
        end
        return c;
    endfunction
endpackage

// File: rtl/owr_ident.sv
module owr_ident
    import owr_pkg::*;
#(
    parameter logic [7:0]  FAMILY = 8'h43,
    parameter logic [47:0] SERIAL = 48'h00A1B2C3D4E5
) (
    input  logic [IDX_W-1:0] idx,
    output logic             id_bit
);
    localparam logic [55:0]     BODY = {SERIAL, FAMILY};
    localparam logic [ID_W-1:0] ID   = {crc8_of(BODY), BODY};

    assign id_bit = ID[idx];
endmodule

// File: rtl/owr_cmd_rx.sv
module owr_cmd_rx
    import owr_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    restart,
    input  logic    active,
    input  logic    wr_slot,
    input  logic    wr_bit,
    output logic    done,
    output owr_op_e op
);
    logic [7:0] shreg;
    logic [2:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            shreg <= '0;
            cnt   <= '0;
        end else if (active && wr_slot) begin
            shreg <= {wr_bit, shreg[7:1]};
            cnt   <= cnt + 3'd1;
        end
    end

    assign done = active && wr_slot && !restart && (cnt == 3'd7);
    assign op   = decode_cmd({wr_bit, shreg[7:1]});
endmodule

// File: rtl/owr_flags.sv
module owr_flags (
    input  logic clk,
    input  logic rst,
    input  logic rc_set,
    input  logic rc_clr,
    input  logic od_set,
    input  logic od_restore,
    input  logic od_clr,
    output logic rc,
    output logic od
);
    logic od_saved;

    always_ff @(posedge clk) begin
        if (rst) begin
            rc <= 1'b0;
        end else if (rc_set) begin
            rc <= 1'b1;
        end else if (rc_clr) begin
            rc <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            od       <= 1'b0;
            od_saved <= 1'b0;
        end else if (od_clr) begin
            od <= 1'b0;
        end else if (od_set) begin
            od_saved <= od;
            od       <= 1'b1;
        end else if (od_restore) begin
            od <= od_saved;
        end
    end
endmodule

// File: rtl/owr_rom_layer.sv
module owr_rom_layer
    import owr_pkg::*;
#(
    parameter logic [7:0]  FAMILY = 8'h43,
    parameter logic [47:0] SERIAL = 48'h00A1B2C3D4E5
) (
    input  logic clk,
    input  logic rst,
    input  logic bus_reset,
    input  logic reset_long,
    input  logic wr_slot,
    input  logic wr_bit,
    input  logic rd_slot,
    output logic tx_bit,
    output logic selected,
    output logic overdrive
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ID_W - 1);

    owr_state_e       st;
    logic [IDX_W-1:0] idx;
    logic             id_bit;
    logic             odm_mode;
    logic             cmd_done;
    owr_op_e          op;
    logic             rc;

    owr_ident #(.FAMILY(FAMILY), .SERIAL(SERIAL)) u_ident (
        .idx(idx), .id_bit(id_bit)
    );

    owr_cmd_rx u_cmd (
        .clk(clk), .rst(rst), .restart(bus_reset), .active(st == ST_CMD),
        .wr_slot(wr_slot), .wr_bit(wr_bit), .done(cmd_done), .op(op)
    );

    logic addr_step, addr_miss, addr_win, rc_clr, od_set, od_restore;
    always_comb begin
        addr_step  = !bus_reset && wr_slot && (st == ST_MATCH || st == ST_S_PICK);
        addr_miss  = addr_step && (wr_bit != id_bit);
        addr_win   = addr_step && (wr_bit == id_bit) && (idx == LAST);
        rc_clr     = addr_miss || (cmd_done && (op == OP_SKIP || op == OP_OD_SKIP));
        od_set     = cmd_done && (op == OP_OD_SKIP || op == OP_OD_MATCH);
        od_restore = addr_miss && (st == ST_MATCH) && odm_mode;
    end

    owr_flags u_flags (
        .clk(clk), .rst(rst), .rc_set(addr_win), .rc_clr(rc_clr),
        .od_set(od_set), .od_restore(od_restore),
        .od_clr(bus_reset && reset_long), .rc(rc), .od(overdrive)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_WAIT;
            idx      <= '0;
            odm_mode <= 1'b0;
        end else if (bus_reset) begin
            st       <= ST_CMD;
            idx      <= '0;
            odm_mode <= 1'b0;
        end else begin
            case (st)
                ST_CMD: if (cmd_done) begin
                    odm_mode <= (op == OP_OD_MATCH);
                    case (op)
                        OP_READ:                 st <= ST_READ;
                        OP_MATCH, OP_OD_MATCH:   st <= ST_MATCH;
                        OP_SEARCH:               st <= ST_S_TRUE;
                        OP_SKIP, OP_OD_SKIP:     st <= ST_SEL;
                        OP_RESUME:               st <= rc ? ST_SEL : ST_WAIT;
                        default:                 st <= ST_WAIT;
                    endcase
                end
                ST_READ: if (rd_slot) begin
                    if (idx == LAST) st <= ST_SEL;
                    else             idx <= idx + 1'b1;
                end
                ST_MATCH: if (wr_slot) begin
                    if (wr_bit != id_bit) st <= ST_WAIT;
                    else if (idx == LAST) st <= ST_SEL;
                    else                  idx <= idx + 1'b1;
                end
                ST_S_TRUE: if (rd_slot) st <= ST_S_COMP;
                ST_S_COMP: if (rd_slot) st <= ST_S_PICK;
                ST_S_PICK: if (wr_slot) begin
                    if (wr_bit != id_bit) st <= ST_WAIT;
                    else if (idx == LAST) st <= ST_SEL;
                    else begin
                        idx <= idx + 1'b1;
                        st  <= ST_S_TRUE;
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        case (st)
            ST_READ, ST_S_TRUE: tx_bit = id_bit;
            ST_S_COMP:          tx_bit = !id_bit;
            default:            tx_bit = 1'b1;
        endcase
    end

    assign selected = (st == ST_SEL);

    p_long_reset_clears_od_r11: assert property (@(posedge clk) disable iff (rst)
        bus_reset && reset_long |=> !overdrive);
    p_short_reset_keeps_od_r11: assert property (@(posedge clk) disable iff (rst)
        bus_reset && !reset_long |=> overdrive == $past(overdrive));
    p_reset_deselects_r12: assert property (@(posedge clk) disable iff (rst)
        bus_reset |=> !selected);
    p_search_complement_r5: assert property (@(posedge clk) disable iff (rst)
        (st == ST_S_COMP && $past(st) == ST_S_TRUE) |-> tx_bit == !$past(tx_bit));
    p_rc_source_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(rc) |-> ($past(st) == ST_MATCH || $past(st) == ST_S_PICK));
    p_released_when_selected_r8: assert property (@(posedge clk) disable iff (rst)
        selected |-> tx_bit);
endmodule

// File: tb/owr_rom_layer_test.sv
module owr_rom_layer_test;
    localparam logic [7:0]  FAM = 8'h43;
    localparam logic [47:0] SER = 48'h00A1B2C3D4E5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_reset = 1'b0, reset_long = 1'b0;
    logic wr_slot = 1'b0, wr_bit = 1'b0, rd_slot = 1'b0;
    logic tx_bit, selected, overdrive;

    int n_run = 0;
    int n_fail = 0;
    logic done = 1'b0;
    logic [63:0] exp_id;

    always #10 clk = ~clk;

    owr_rom_layer #(.FAMILY(FAM), .SERIAL(SER)) uut (
        .clk(clk), .rst(rst), .bus_reset(bus_reset), .reset_long(reset_long),
        .wr_slot(wr_slot), .wr_bit(wr_bit), .rd_slot(rd_slot),
        .tx_bit(tx_bit), .selected(selected), .overdrive(overdrive)
    );

    function automatic logic [7:0] ref_crc(input logic [55:0] d);
        logic [7:0] c = 8'h00;
        for (int i = 0; i < 56; i++) begin
            if (c[0] ^ d[i]) c = (c >> 1) ^ 8'h8C;
            else             c = c >> 1;
        end
        return c;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_rst(input logic lng);
        bus_reset = 1'b1; reset_long = lng;
        @(negedge clk);
        bus_reset = 1'b0; reset_long = 1'b0;
        @(negedge clk);
    endtask

    task automatic wbit(input logic b);
        wr_slot = 1'b1; wr_bit = b;
        @(negedge clk);
        wr_slot = 1'b0;
        @(negedge clk);
    endtask

    task automatic wbyte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) wbit(v[i]);
    endtask

    task automatic rbit(output logic b);
        b = tx_bit;
        rd_slot = 1'b1;
        @(negedge clk);
        rd_slot = 1'b0;
        @(negedge clk);
    endtask

    task automatic probe_resume(input logic exp, input string req);
        bus_rst(1'b0);
        wbyte(8'hA5);
        check(req, 64'(selected), 64'(exp));
    endtask

    initial begin
        logic [63:0] got;
        logic b, c;
        exp_id = {ref_crc({SER, FAM}), SER, FAM};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 selected", 64'(selected), 64'd0);
        check("R1 overdrive", 64'(overdrive), 64'd0);
        check("R1 tx_bit", 64'(tx_bit), 64'd1);

        // R12 slots before first bus reset are ignored
        wbyte(8'hCC);
        check("R12 pre-reset skip ignored", 64'(selected), 64'd0);
        probe_resume(1'b0, "R1 resume flag clear");

        // R3 read ROM
        bus_rst(1'b0);
        wbyte(8'h33);
        got = '0;
        for (int i = 0; i < 64; i++) begin
            rbit(b);
            got[i] = b;
        end
        check("R3 identity", got, exp_id);
        check("R3 selected after read", 64'(selected), 64'd1);

        // R8 skip
        bus_rst(1'b0);
        check("R12 reset deselects", 64'(selected), 64'd0);
        wbyte(8'hCC);
        check("R8 skip selects", 64'(selected), 64'd1);
        check("R8 skip keeps speed", 64'(overdrive), 64'd0);
        check("R8 released while selected", 64'(tx_bit), 64'd1);

        // R4/R6/R7 successful match sets resume flag
        bus_rst(1'b0);
        wbyte(8'h55);
        for (int i = 0; i < 64; i++) wbit(exp_id[i]);
        check("R4 match selects", 64'(selected), 64'd1);
        probe_resume(1'b1, "R7 resume after match");

        // R4/R6 mismatch sweep over every bit position
        for (int k = 0; k < 64; k++) begin
            bus_rst(1'b0);
            wbyte(8'h55);
            for (int i = 0; i < 64; i++) wbit(i == k ? !exp_id[i] : exp_id[i]);
            check($sformatf("R4 mismatch bit %0d", k), 64'(selected), 64'd0);
            probe_resume(1'b0, $sformatf("R6 failed match clears rc bit %0d", k));
            bus_rst(1'b0);
            wbyte(8'h55);
            for (int i = 0; i < 64; i++) wbit(exp_id[i]);
        end

        // R6 skip clears the resume flag
        bus_rst(1'b0);
        wbyte(8'hCC);
        probe_resume(1'b0, "R6 skip clears rc");

        // R5 full search
        bus_rst(1'b0);
        wbyte(8'hF0);
        for (int i = 0; i < 64; i++) begin
            rbit(b);
            rbit(c);
            check($sformatf("R5 true bit %0d", i), 64'(b), 64'(exp_id[i]));
            check($sformatf("R5 comp bit %0d", i), 64'(c), 64'(!exp_id[i]));
            wbit(exp_id[i]);
        end
        check("R5 search selects", 64'(selected), 64'd1);
        probe_resume(1'b1, "R6 search sets rc");

        // R5 search drop-out sweep
        for (int k = 0; k < 64; k++) begin
            bus_rst(1'b0);
            wbyte(8'hF0);
            for (int i = 0; i <= k; i++) begin
                rbit(b);
                rbit(c);
                wbit(i == k ? !exp_id[i] : exp_id[i]);
            end
            rbit(b);
            rbit(c);
            check($sformatf("R5 released after loss %0d", k), {62'd0, b, c}, 64'd3);
            check($sformatf("R5 loss unselected %0d", k), 64'(selected), 64'd0);
            probe_resume(1'b0, $sformatf("R6 failed search clears rc %0d", k));
        end

        // R2 unknown command
        bus_rst(1'b0);
        wbyte(8'h00);
        check("R2 unknown unselected", 64'(selected), 64'd0);
        rbit(b);
        check("R2 unknown released", 64'(b), 64'd1);
        wbyte(8'hCC);
        check("R2 later slots ignored", 64'(selected), 64'd0);

        // R9/R11 overdrive skip and resets
        bus_rst(1'b0);
        wbyte(8'h3C);
        check("R9 od skip selects", 64'(selected), 64'd1);
        check("R9 od skip sets od", 64'(overdrive), 64'd1);
        bus_rst(1'b0);
        check("R11 short reset keeps od", 64'(overdrive), 64'd1);
        bus_rst(1'b1);
        check("R11 long reset clears od", 64'(overdrive), 64'd0);

        // R10 overdrive match failing from standard speed
        bus_rst(1'b1);
        wbyte(8'h69);
        check("R10 od set after command", 64'(overdrive), 64'd1);
        wbit(!exp_id[0]);
        check("R10 od restored after miss", 64'(overdrive), 64'd0);
        check("R10 miss unselected", 64'(selected), 64'd0);

        // R10 successful overdrive match
        bus_rst(1'b0);
        wbyte(8'h69);
        for (int i = 0; i < 64; i++) wbit(exp_id[i]);
        check("R10 od match selects", 64'(selected), 64'd1);
        check("R10 od match keeps od", 64'(overdrive), 64'd1);
        probe_resume(1'b1, "R6 od match sets rc");

        // R10 failing while already in overdrive
        bus_rst(1'b0);
        wbyte(8'h69);
        for (int i = 0; i < 5; i++) wbit(i == 4 ? !exp_id[i] : exp_id[i]);
        check("R10 od kept on miss", 64'(overdrive), 64'd1);
        probe_resume(1'b0, "R6 failed od match clears rc");
        bus_rst(1'b1);
        check("R11 long reset after od match", 64'(overdrive), 64'd0);

        done = 1'b1;
    end

    initial begin
        for (int cyc = 0; cyc < 200000 && !done; cyc++) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=done");
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule